// File: doc/BRIEF.md
# Multi-Master GPIO Pin Multiplexer

This block controls a small port of general-purpose pins. For every pin it decides who drives the pad. The output can come from one of up to twelve peripheral functions, or it can be in CPU mode. In CPU mode the data and direction come from whichever of two CPU masters is assigned to that pin. The input path is built on its own: a synchronizer and a qualifier per pin. Its only output is a level that both masters share, so the pin can be read whatever currently drives it. Polarity inversion, open-drain drive and qualification apply to the pin itself, whatever the owner.

Configuration is written one field at a time through a small write port. The port carries a source bit, and only the primary master may change anything. A debug path on one designated pin overrides the output and returns the raw pad level, skipping inversion and qualification. Some pins start in analog mode and must be released by software before they act digitally. Other pins are input-only.

Top module: `pinmux_port`

## Requirements
- R1: With function select 0 (CPU mode), a pin's pad_out and pad_oe equal the data and direction bits of master 1 when its master-select bit is 0, and of master 2 when that bit is 1, in the same cycle.
- R2: With function select k, where 1 <= k <= 12, a pin p drives pad_out and pad_oe from peripheral bit p*12+k-1 of periph_out and periph_oe.
- R3: A function-select write with a value above 12 is dropped, and the pin keeps its previous function.
- R4: pin_level follows the pad no matter which function owns the output, and both masters read this same level.
- R5: A write with cfg_src=1 (master 2) changes no configuration. Writes with cfg_src=0 take effect at the next clock edge. The cfg_sel codes are: 0 function (data[3:0]), 1 master select (data[0]), 2 options (data[0] invert, data[1] open-drain, data[3:2] qualification), 3 analog select (data[0]), 4 sample period (data[7:0], shared by all pins).
- R6: Qualification code 0 (synchronous) shows a pad change on pin_level exactly three clock edges later. Codes 1 and 2 accept a new level only after 3 or 6 equal samples, taken once every period+1 cycles. Shorter pulses are rejected.
- R7: When open-drain is set, the pin drives low only when the owner's value is 0 with its enable set. Otherwise pad_oe is 0, and pad_out is always 0.
- R8: With the invert bit set, pin_level is the complement of the qualified pad level.
- R9: With dbg_en high, pin 0 drives dbg_out and dbg_oe directly, ignoring inversion and open-drain. dbg_in always equals the raw pad_in[0] in the same cycle, without synchronization or inversion.
- R10: Pin 2 comes out of reset in analog mode: pad_oe 0 and pin_level 0. Once its analog-select bit is cleared it behaves as a normal pin.
- R11: Pin 3 is input-only: pad_oe stays 0 always, and pin_level still follows its pad.
- R12: After reset every pin is in CPU mode with master 1, inversion and open-drain off, synchronous qualification and sample period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Writing master: 0 primary, 1 secondary |
| cfg_sel | input | 3 | Field selector |
| cfg_pin | input | 2 | Target pin |
| cfg_data | input | 8 | Write data |
| m1_out | input | 4 | Master 1 output data per pin |
| m1_dir | input | 4 | Master 1 direction per pin (1 = drive) |
| m2_out | input | 4 | Master 2 output data per pin |
| m2_dir | input | 4 | Master 2 direction per pin |
| periph_out | input | 48 | Peripheral output values, 12 per pin |
| periph_oe | input | 48 | Peripheral output enables, 12 per pin |
| dbg_en | input | 1 | Debug override on pin 0 |
| dbg_out | input | 1 | Debug output value |
| dbg_oe | input | 1 | Debug output enable |
| dbg_in | output | 1 | Raw pad level of pin 0 |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| pin_level | output | 4 | Qualified, polarity-adjusted level seen by both masters |

## Verification
The debug override and the pin options can act on pin 0 in the same cycle. The bench sets both inversion and open-drain on pin 0 and then raises dbg_en. It judges the case by three results. pad_out and pad_oe must carry the debug values unaltered. dbg_in must track every pad_in[0] change in the same cycle. pin_level[0] must still show the inverted, synchronized level three edges later. A second collision is a qualification sample tick falling inside a short pad pulse: such pulses are timed so that fewer ticks land on them than the mode needs, and the level must not move.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int FUNC_W = 4;

  localparam logic [2:0] SEL_FUNC = 3'd0;
  localparam logic [2:0] SEL_MSTR = 3'd1;
  localparam logic [2:0] SEL_OPTS = 3'd2;
  localparam logic [2:0] SEL_ANA  = 3'd3;
  localparam logic [2:0] SEL_PER  = 3'd4;

  typedef enum logic [1:0] {
    QUAL_SYNC = 2'd0,
    QUAL_S3   = 2'd1,
    QUAL_S6   = 2'd2
  } qual_e;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              msel;
    logic              inv;
    logic              od;
    qual_e             qual;
    logic              ana;
  } pin_cfg_t;

  // A function code is legal when it names CPU mode or an existing peripheral.
  function automatic logic func_legal(input logic [FUNC_W-1:0] code, input int nper);
    return int'(code) <= nper;
  endfunction

  // Number of equal samples a qualification mode demands.
  function automatic int window_len(input qual_e mode);
    return (mode == QUAL_S3) ? 3 : 6;
  endfunction

  // True when the newest len samples in hist all agree.
  function automatic logic window_agrees(input logic [5:0] hist, input int len);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < 6; i++)
      if (i < len && hist[i] != hist[0]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/pinmux_cfg.sv
module pinmux_cfg
  import pinmux_pkg::*;
#(
  parameter int          NPINS         = 4,
  parameter int          NPERIPH       = 12,
  parameter logic [NPINS-1:0] ANA_MODE_MASK = '0,
  localparam int         PIN_W         = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_src,
  input  logic [2:0]            cfg_sel,
  input  logic [PIN_W-1:0]      cfg_pin,
  input  logic [7:0]            cfg_data,
  output pin_cfg_t [NPINS-1:0]  cfg_q,
  output logic [7:0]            period_q
);

  logic write_ok;
  logic pin_in_range;

  assign pin_in_range = int'(cfg_pin) < NPINS;
  assign write_ok     = cfg_we && !cfg_src && pin_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) begin
        cfg_q[p].func <= '0;
        cfg_q[p].msel <= 1'b0;
        cfg_q[p].inv  <= 1'b0;
        cfg_q[p].od   <= 1'b0;
        cfg_q[p].qual <= QUAL_SYNC;
        cfg_q[p].ana  <= ANA_MODE_MASK[p];
      end
      period_q <= '0;
    end else if (write_ok) begin
      case (cfg_sel)
        SEL_FUNC: if (func_legal(cfg_data[FUNC_W-1:0], NPERIPH))
                    cfg_q[cfg_pin].func <= cfg_data[FUNC_W-1:0];
        SEL_MSTR: cfg_q[cfg_pin].msel <= cfg_data[0];
        SEL_OPTS: begin
          cfg_q[cfg_pin].inv  <= cfg_data[0];
          cfg_q[cfg_pin].od   <= cfg_data[1];
          cfg_q[cfg_pin].qual <= qual_e'(cfg_data[3:2]);
        end
        SEL_ANA:  if (ANA_MODE_MASK[cfg_pin]) cfg_q[cfg_pin].ana <= cfg_data[0];
        SEL_PER:  period_q <= cfg_data;
        default:  ;
      endcase
    end
  end

  assert_m2_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_src) |=> ($stable(cfg_q) && $stable(period_q)));

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    assert_func_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cfg_q[p].func) <= NPERIPH);
  end

endmodule

// File: rtl/pin_qual.sv
module pin_qual
  import pinmux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pad,
  input  logic  tick,
  input  qual_e mode,
  output logic  lvl
);

  logic       s1_q, s2_q, lvl_q;
  logic [5:0] hist_q;
  logic [5:0] hist_next;
  logic       sampled_mode;
  logic       accept;

  assign sampled_mode = (mode != QUAL_SYNC);
  assign hist_next    = {hist_q[4:0], s2_q};
  assign accept       = tick && window_agrees(hist_next, window_len(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      s1_q <= pad;
      s2_q <= s1_q;
      if (tick) hist_q <= hist_next;
      if (!sampled_mode)  lvl_q <= s2_q;
      else if (accept)    lvl_q <= hist_next[0];
    end
  end

  assign lvl = lvl_q;

  assert_qual_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled_mode && !tick) |=> $stable(lvl_q));

endmodule

// File: rtl/pin_outmux.sv
module pin_outmux
  import pinmux_pkg::*;
#(
  parameter int   NPERIPH  = 12,
  parameter logic ANA_ONLY = 1'b0,
  parameter logic IS_DBG   = 1'b0
) (
  input  pin_cfg_t           cfg,
  input  logic               m1_o,
  input  logic               m1_d,
  input  logic               m2_o,
  input  logic               m2_d,
  input  logic [NPERIPH-1:0] per_o,
  input  logic [NPERIPH-1:0] per_e,
  input  logic               dbg_en,
  input  logic               dbg_o,
  input  logic               dbg_e,
  output logic               pad_out,
  output logic               pad_oe
);

  logic own_val, own_en;
  logic dbg_take;
  logic [FUNC_W-1:0] idx;

  assign dbg_take = IS_DBG && dbg_en;
  assign idx      = cfg.func - 1'b1;

  always_comb begin
    own_val = 1'b0;
    own_en  = 1'b0;
    if (cfg.func == '0) begin
      own_val = cfg.msel ? m2_o : m1_o;
      own_en  = cfg.msel ? m2_d : m1_d;
    end else if (int'(cfg.func) <= NPERIPH) begin
      own_val = per_o[idx];
      own_en  = per_e[idx];
    end
  end

  always_comb begin
    if (dbg_take) begin
      pad_out = dbg_o;
      pad_oe  = dbg_e;
    end else if (cfg.od) begin
      pad_out = 1'b0;
      pad_oe  = own_en && !own_val;
    end else begin
      pad_out = own_val;
      pad_oe  = own_en;
    end
    if (ANA_ONLY || cfg.ana) pad_oe = 1'b0;
  end

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int               NPINS         = 4,
  parameter int               NPERIPH       = 12,
  parameter int               DBG_PIN       = 0,
  parameter logic [NPINS-1:0] ANA_MODE_MASK = 4'b0100,
  parameter logic [NPINS-1:0] ANA_ONLY_MASK = 4'b1000,
  localparam int              PIN_W         = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int              PER_BITS      = NPINS * NPERIPH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_src,
  input  logic [2:0]          cfg_sel,
  input  logic [PIN_W-1:0]    cfg_pin,
  input  logic [7:0]          cfg_data,
  input  logic [NPINS-1:0]    m1_out,
  input  logic [NPINS-1:0]    m1_dir,
  input  logic [NPINS-1:0]    m2_out,
  input  logic [NPINS-1:0]    m2_dir,
  input  logic [PER_BITS-1:0] periph_out,
  input  logic [PER_BITS-1:0] periph_oe,
  input  logic                dbg_en,
  input  logic                dbg_out,
  input  logic                dbg_oe,
  output logic                dbg_in,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_oe,
  output logic [NPINS-1:0]    pin_level
);

  pin_cfg_t [NPINS-1:0] cfg_q;
  logic [7:0]           period_q;
  logic [7:0]           div_q;
  logic                 sample_tick;
  logic [NPINS-1:0]     qual_lvl;

  pinmux_cfg #(
    .NPINS(NPINS), .NPERIPH(NPERIPH), .ANA_MODE_MASK(ANA_MODE_MASK)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_sel(cfg_sel), .cfg_pin(cfg_pin), .cfg_data(cfg_data),
    .cfg_q(cfg_q), .period_q(period_q)
  );

  // Shared sampling divider: one tick every period_q+1 cycles.
  assign sample_tick = (div_q == period_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           div_q <= '0;
    else if (sample_tick) div_q <= '0;
    else                  div_q <= div_q + 8'd1;
  end

  assign dbg_in = pad_in[DBG_PIN];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_qual u_qual (
      .clk(clk), .rst_n(rst_n), .pad(pad_in[p]), .tick(sample_tick),
      .mode(cfg_q[p].qual), .lvl(qual_lvl[p])
    );

    assign pin_level[p] = cfg_q[p].ana ? 1'b0 : (qual_lvl[p] ^ cfg_q[p].inv);

    pin_outmux #(
      .NPERIPH(NPERIPH), .ANA_ONLY(ANA_ONLY_MASK[p]), .IS_DBG(p == DBG_PIN)
    ) u_out (
      .cfg(cfg_q[p]), .m1_o(m1_out[p]), .m1_d(m1_dir[p]),
      .m2_o(m2_out[p]), .m2_d(m2_dir[p]),
      .per_o(periph_out[p*NPERIPH +: NPERIPH]),
      .per_e(periph_oe[p*NPERIPH +: NPERIPH]),
      .dbg_en(dbg_en), .dbg_o(dbg_out), .dbg_e(dbg_oe),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );

    assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[p].od && !(dbg_en && p == DBG_PIN)) |-> !pad_out[p]);

    assert_analog_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ANA_ONLY_MASK[p] || cfg_q[p].ana) |-> !pad_oe[p]);

    assert_analog_reads_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[p].ana |-> !pin_level[p]);
  end

endmodule

// File: tb/pinmux_port_tb_top.sv
module pinmux_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_src = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  cfg_pin = '0;
  logic [7:0]  cfg_data = '0;
  logic [3:0]  m1_out = '0, m1_dir = '0, m2_out = '0, m2_dir = '0;
  logic [47:0] periph_out = '0, periph_oe = '0;
  logic        dbg_en = 1'b0, dbg_out = 1'b0, dbg_oe = 1'b0;
  logic        dbg_in;
  logic [3:0]  pad_in = '0;
  logic [3:0]  pad_out, pad_oe, pin_level;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pinmux_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_sel(cfg_sel), .cfg_pin(cfg_pin), .cfg_data(cfg_data),
    .m1_out(m1_out), .m1_dir(m1_dir), .m2_out(m2_out), .m2_dir(m2_dir),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .dbg_en(dbg_en), .dbg_out(dbg_out), .dbg_oe(dbg_oe), .dbg_in(dbg_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level)
  );

  // Each entry: {func[3:0], msel, od, expected pad_out, expected pad_oe} for pin 0.
  localparam logic [7:0] VEC [10] = '{
    8'b0000_0011, 8'b0000_1001, 8'b0000_0100, 8'b0000_1101, 8'b0001_0011,
    8'b0010_0001, 8'b0111_0011, 8'b1100_0000, 8'b0010_0101, 8'b0101_0100
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic src, input logic [2:0] sel, input logic [1:0] pin,
                    input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_src = src; cfg_sel = sel; cfg_pin = pin; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_src = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=below 100000", cycle);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Peripheral k on pin 0 drives k[0]; peripheral 12 has its enable low.
    for (int k = 1; k <= 12; k++) begin
      periph_out[k-1] = k[0];
      periph_oe[k-1]  = (k != 12);
    end
    periph_oe[12 +: 12] = '1;   // pin 1 peripherals drive 0 with enable
    wait_n(3);
    #1 check("R12 reset oe", pad_oe, 4'b0000);
    check("R12 reset level", pin_level, 4'b0000);
    rst_n = 1'b1;
    wait_n(2);
    m1_out = 4'b1111; m1_dir = 4'b1111; m2_out = 4'b0000; m2_dir = 4'b1111;
    #1 check("R12 master1 owns, R10 R11 analog pins idle", pad_oe, 4'b0011);
    check("R12 master1 data", pad_out, 4'b1111);

    // Table walk on pin 0: R1 CPU ownership, R2 peripheral ownership, R7 open-drain.
    for (int i = 0; i < 10; i++) begin
      wr(1'b0, 3'd0, 2'd0, {4'd0, VEC[i][7:4]});
      wr(1'b0, 3'd1, 2'd0, {7'd0, VEC[i][3]});
      wr(1'b0, 3'd2, 2'd0, {6'd0, VEC[i][2], 1'b0});
      #1 check($sformatf("R1 R2 R7 vec%0d out", i), pad_out[0], VEC[i][1]);
      check($sformatf("R1 R2 R7 vec%0d oe", i), pad_oe[0], VEC[i][0]);
    end

    // R3: illegal function code dropped.
    wr(1'b0, 3'd2, 2'd0, 8'd0);
    wr(1'b0, 3'd0, 2'd0, 8'd2);
    wr(1'b0, 3'd0, 2'd0, 8'd13);
    #1 check("R3 func 13 ignored out", pad_out[0], 1'b0);
    check("R3 func 13 ignored oe", pad_oe[0], 1'b1);

    // R5: master 2 cannot change function or master select.
    wr(1'b1, 3'd0, 2'd0, 8'd1);
    wr(1'b1, 3'd2, 2'd0, 8'd2);
    #1 check("R5 m2 func write ignored", pad_out[0], 1'b0);
    check("R5 m2 opts write ignored", pad_oe[0], 1'b1);

    // R4: peripheral owns pin 1 (drives 0), pin level still follows the pad.
    wr(1'b0, 3'd0, 2'd1, 8'd3);
    pad_in[1] = 1'b1;
    wait_n(4);
    check("R4 level while peripheral drives", pin_level[1], 1'b1);
    check("R4 peripheral still owns", {pad_out[1], pad_oe[1]}, 2'b01);

    // R8: inversion.
    wr(1'b0, 3'd2, 2'd1, 8'd1);
    #1 check("R8 inverted level", pin_level[1], 1'b0);

    // R6 synchronous latency: three edges.
    wr(1'b0, 3'd2, 2'd1, 8'd0);
    pad_in[1] = 1'b0;
    wait_n(4);
    pad_in[1] = 1'b1;
    wait_n(2);
    check("R6 sync two edges old", pin_level[1], 1'b0);
    wait_n(1);
    check("R6 sync three edges new", pin_level[1], 1'b1);
    pad_in[1] = 1'b0;
    wait_n(4);

    // R6 3-sample mode, period 3 (tick every 4 cycles).
    wr(1'b0, 3'd4, 2'd0, 8'd3);
    wr(1'b0, 3'd2, 2'd1, 8'd4);
    pad_in[1] = 1'b1; wait_n(4); pad_in[1] = 1'b0;
    wait_n(30);
    check("R6 3-sample glitch rejected", pin_level[1], 1'b0);
    pad_in[1] = 1'b1; wait_n(40);
    check("R6 3-sample level accepted", pin_level[1], 1'b1);

    // R6 6-sample mode: 12-cycle low pulse rejected.
    wr(1'b0, 3'd2, 2'd1, 8'd8);
    pad_in[1] = 1'b0; wait_n(12); pad_in[1] = 1'b1;
    wait_n(40);
    check("R6 6-sample glitch rejected", pin_level[1], 1'b1);
    pad_in[1] = 1'b0; wait_n(60);
    check("R6 6-sample level accepted", pin_level[1], 1'b0);

    // R9: debug override with inversion and open-drain set on pin 0.
    wr(1'b0, 3'd2, 2'd0, 8'd3);
    dbg_en = 1'b1; dbg_out = 1'b1; dbg_oe = 1'b1;
    #1 check("R9 debug drives unaltered", {pad_out[0], pad_oe[0]}, 2'b11);
    pad_in[0] = 1'b1;
    #1 check("R9 dbg_in raw same cycle", dbg_in, 1'b1);
    wait_n(4);
    check("R9 pin level still inverted", pin_level[0], 1'b0);
    pad_in[0] = 1'b0;
    #1 check("R9 dbg_in follows low", dbg_in, 1'b0);
    dbg_en = 1'b0;

    // R10: pin 2 analog until released.
    pad_in[2] = 1'b1;
    wait_n(4);
    check("R10 analog level low", pin_level[2], 1'b0);
    check("R10 analog no drive", pad_oe[2], 1'b0);
    wr(1'b1, 3'd3, 2'd2, 8'd0);
    wait_n(4);
    check("R10 m2 cannot release analog", pin_level[2], 1'b0);
    wr(1'b0, 3'd3, 2'd2, 8'd0);
    wait_n(4);
    check("R10 released level", pin_level[2], 1'b1);
    check("R10 released drive", pad_oe[2], 1'b1);

    // R11: pin 3 input-only.
    pad_in[3] = 1'b1;
    wr(1'b0, 3'd3, 2'd3, 8'd0);
    wait_n(4);
    check("R11 input-only readable", pin_level[3], 1'b1);
    check("R11 input-only no drive", pad_oe[3], 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule